// File: doc/BRIEF.md
# Position Result Buffer with Host Handshake

This block sits between an encoder read engine and a 16-bit host processor. It holds 128 bytes. The read engine fills the storage one byte at a time through a narrow write port. The host fetches whole 16-bit words through a synchronous read port. Two neighbouring bytes form one word, with the lower address in the low half.

The host opens each acquisition with a single-cycle begin pulse, once per control-loop period. The buffer then enters its busy state and sends the read engine a one-cycle start pulse. While busy, the engine writes the bytes of the new result and then raises its done line. The buffer answers with a one-cycle end pulse, which the host uses as an interrupt. It also sets a sticky completion flag that the host can poll. Bytes arriving outside an acquisition are dropped, so a stray write cannot corrupt a result the host is reading. A begin pulse that arrives mid-acquisition is refused and recorded in an overrun flag.

Top module: `pos_result_buf`

## Requirements
- R1: While reset is asserted and after its release, busy_o, start_o, end_o, end_flag_o, overrun_o and rd_data_o are all 0.
- R2: A begin_i pulse sampled while idle is accepted. In the next cycle busy_o is 1, start_o is 1 for exactly one cycle, and end_flag_o and overrun_o are 0.
- R3: A byte write (wr_en_i) while busy stores wr_data_i at byte address wr_addr_i. Word k reads back as {byte 2k+1, byte 2k}: the even byte is bits 7:0 and the odd byte is bits 15:8.
- R4: rd_en_i with word address rd_addr_i loads rd_data_o on the next clock edge. rd_data_o holds that value while rd_en_i is low.
- R5: Byte writes while idle are ignored. Storage content is unchanged.
- R6: done_i sampled while busy ends the acquisition. In the next cycle busy_o is 0, end_o is 1 for exactly one cycle, and end_flag_o is 1.
- R7: end_flag_o stays 1 until the next accepted begin pulse clears it.
- R8: A begin_i sampled while busy is ignored. No start pulse is sent and busy_o stays 1. overrun_o is set and stays 1 until the next accepted begin pulse.
- R9: done_i sampled while idle has no effect. end_o stays 0.
- R10: Every byte address from 0 to 127 is writable, and every word address from 0 to 63 is readable, including the first and last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_i | input | 1 | Host request to start an acquisition |
| start_o | output | 1 | One-cycle start command to the read engine |
| busy_o | output | 1 | Acquisition in progress |
| wr_en_i | input | 1 | Byte write strobe from the read engine |
| wr_addr_i | input | 7 | Byte address |
| wr_data_i | input | 8 | Byte data |
| done_i | input | 1 | Read engine has written the full result |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 6 | Word address |
| rd_data_o | output | 16 | Word data, registered |
| end_o | output | 1 | One-cycle completion interrupt |
| end_flag_o | output | 1 | Sticky completion status |
| overrun_o | output | 1 | Sticky refused-begin status |

## Verification
A wrong sequencer state shows up one cycle after the begin or done input, as a missing or extra pulse on start_o or end_o, or as a wrong level on busy_o, end_flag_o or overrun_o. Storage faults stay hidden until the host reads the affected word, one cycle after the read strobe. Swapped lanes, lost writes and idle-time writes that should have been dropped therefore appear only at read time. For this reason every scenario ends by reading back the words it touched.

// File: rtl/pos_result_buf_pkg.sv
package pos_result_buf_pkg;
  typedef enum logic {
    ACQ_IDLE = 1'b0,
    ACQ_BUSY = 1'b1
  } acq_state_e;
endpackage

// File: rtl/pos_result_buf_mem.sv
module pos_result_buf_mem #(
  parameter int BYTES  = 128,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int BA_W   = $clog2(BYTES),
  localparam int WA_W   = BA_W - LANE_W,
  localparam int WORDS  = BYTES / LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BA_W-1:0]   waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [WA_W-1:0]   raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WA_W-1:0]   w_word;
  logic [LANE_W-1:0] w_lane;

  assign w_word = waddr_i[BA_W-1:LANE_W];
  assign w_lane = waddr_i[LANE_W-1:0];

  // one byte-wide array per lane; low byte address goes to the low lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem [WORDS];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && (w_lane == LANE_W'(l))) mem[w_word] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= mem[raddr_i];
    end

    assign rdata_o[l*BYTE_W +: BYTE_W] = rd_q;
  end
endmodule

// File: rtl/pos_result_buf_seq.sv
module pos_result_buf_seq
  import pos_result_buf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic begin_i,
  input  logic done_i,
  input  logic wr_en_i,
  output logic wr_ok_o,
  output logic busy_o,
  output logic start_o,
  output logic end_o,
  output logic end_flag_o,
  output logic overrun_o
);
  acq_state_e state_q, state_d;
  logic accept, finish, refuse;

  assign accept = begin_i && (state_q == ACQ_IDLE);
  assign refuse = begin_i && (state_q == ACQ_BUSY);
  assign finish = done_i  && (state_q == ACQ_BUSY);

  always_comb begin
    state_d = state_q;
    if (accept)      state_d = ACQ_BUSY;
    else if (finish) state_d = ACQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ACQ_IDLE;
      start_o    <= 1'b0;
      end_o      <= 1'b0;
      end_flag_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_o <= accept;
      end_o   <= finish;
      if (accept)      end_flag_o <= 1'b0;
      else if (finish) end_flag_o <= 1'b1;
      if (accept)      overrun_o  <= 1'b0;
      else if (refuse) overrun_o  <= 1'b1;
    end
  end

  assign busy_o  = (state_q == ACQ_BUSY);
  assign wr_ok_o = wr_en_i && busy_o;
endmodule

// File: rtl/pos_result_buf.sv
module pos_result_buf #(
  parameter int BYTES  = 128,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  localparam int LANES = WORD_W / BYTE_W,
  localparam int BA_W  = $clog2(BYTES),
  localparam int WA_W  = $clog2(BYTES / LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  output logic              start_o,
  output logic              busy_o,
  input  logic              wr_en_i,
  input  logic [BA_W-1:0]   wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              done_i,
  input  logic              rd_en_i,
  input  logic [WA_W-1:0]   rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              end_o,
  output logic              end_flag_o,
  output logic              overrun_o
);
  logic wr_ok;

  pos_result_buf_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .begin_i    (begin_i),
    .done_i     (done_i),
    .wr_en_i    (wr_en_i),
    .wr_ok_o    (wr_ok),
    .busy_o     (busy_o),
    .start_o    (start_o),
    .end_o      (end_o),
    .end_flag_o (end_flag_o),
    .overrun_o  (overrun_o)
  );

  pos_result_buf_mem #(
    .BYTES  (BYTES),
    .BYTE_W (BYTE_W),
    .WORD_W (WORD_W)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .re_i    (rd_en_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/pos_result_buf_chk.sv
module pos_result_buf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic begin_i,
  input logic done_i,
  input logic start_o,
  input logic busy_o,
  input logic end_o,
  input logic end_flag_o,
  input logic overrun_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!busy_o && !start_o && !end_o && !end_flag_o && !overrun_o);
    end
  end

  assert_begin_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (begin_i && !busy_o) |=> (start_o && busy_o && !end_flag_o && !overrun_o));

  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_done_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_o && !begin_i) |=> (end_o && end_flag_o && !busy_o));

  assert_end_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_flag_o && !(begin_i && !busy_o)) |=> end_flag_o);

  assert_refused_begin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (begin_i && busy_o) |=> (overrun_o && !start_o));

  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !(begin_i && !busy_o)) |=> overrun_o);

  assert_idle_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !busy_o) |=> !end_o);
endmodule

bind pos_result_buf pos_result_buf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .begin_i    (begin_i),
  .done_i     (done_i),
  .start_o    (start_o),
  .busy_o     (busy_o),
  .end_o      (end_o),
  .end_flag_o (end_flag_o),
  .overrun_o  (overrun_o)
);

// File: tb/pos_result_buf_tb_top.sv
module pos_result_buf_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        begin_i = 1'b0;
  logic        start_o, busy_o;
  logic        wr_en_i = 1'b0;
  logic [6:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        done_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [5:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        end_o, end_flag_o, overrun_o;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 1'b0;

  always #10 clk_i = ~clk_i;

  pos_result_buf dut_i (
    .clk_i, .rst_ni, .begin_i, .start_o, .busy_o, .wr_en_i, .wr_addr_i,
    .wr_data_i, .done_i, .rd_en_i, .rd_addr_i, .rd_data_o, .end_o,
    .end_flag_o, .overrun_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; registered outputs are read there too
  task automatic pulse_begin();
    @(negedge clk_i) begin_i = 1'b1;
    @(negedge clk_i) begin_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk_i) done_i = 1'b1;
    @(negedge clk_i) done_i = 1'b0;
  endtask

  task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk_i) begin wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; end
    @(negedge clk_i) wr_en_i = 1'b0;
  endtask

  task automatic rd_word(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i) begin rd_en_i = 1'b1; rd_addr_i = a; end
    @(negedge clk_i) rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 flags in reset", {busy_o, start_o, end_o, end_flag_o, overrun_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 flags after reset", {busy_o, start_o, end_o, end_flag_o, overrun_o}, 0);
    chk("R1 rd_data after reset", rd_data_o, 0);
  endtask

  task automatic t_acquire();
    logic [15:0] w;
    pulse_begin();
    chk("R2 start pulse", start_o, 1);
    chk("R2 busy", busy_o, 1);
    @(negedge clk_i);
    chk("R2 start single cycle", start_o, 0);
    for (int i = 0; i < 8; i++) wr_byte(7'(i), 8'(8'h10 + i * 8'h11));
    pulse_done();
    chk("R6 end pulse", end_o, 1);
    chk("R6 end flag", end_flag_o, 1);
    chk("R6 not busy", busy_o, 0);
    @(negedge clk_i);
    chk("R6 end single cycle", end_o, 0);
    for (int k = 0; k < 4; k++) begin
      rd_word(6'(k), w);
      chk("R3 little-endian word",
          w, {16'h0, 8'(8'h10 + (2*k+1) * 8'h11), 8'(8'h10 + 2*k * 8'h11)});
    end
    repeat (3) @(negedge clk_i);
    chk("R4 rd_data holds", rd_data_o, 16'h8776);
  endtask

  task automatic t_idle_ignored();
    logic [15:0] w;
    wr_byte(7'd2, 8'hEE);
    rd_word(6'd1, w);
    chk("R5 idle write dropped", w, 16'h4332);
    pulse_done();
    chk("R9 idle done no end", end_o, 0);
    chk("R9 idle done no busy", busy_o, 0);
  endtask

  task automatic t_flag_sticky();
    repeat (5) @(negedge clk_i);
    chk("R7 end flag held", end_flag_o, 1);
    pulse_begin();
    chk("R7 end flag cleared by begin", end_flag_o, 0);
  endtask

  task automatic t_overrun();
    // acquisition already running from t_flag_sticky
    pulse_begin();
    chk("R8 no start when busy", start_o, 0);
    chk("R8 overrun set", overrun_o, 1);
    chk("R8 still busy", busy_o, 1);
    pulse_done();
    chk("R8 overrun held past end", overrun_o, 1);
    pulse_begin();
    chk("R8 overrun cleared", overrun_o, 0);
    chk("R8 accepted begin starts", start_o, 1);
  endtask

  task automatic t_bounds();
    logic [15:0] w;
    wr_byte(7'd0,   8'hA5);
    wr_byte(7'd1,   8'h5A);
    wr_byte(7'd126, 8'hC3);
    wr_byte(7'd127, 8'h3C);
    pulse_done();
    rd_word(6'd63, w);
    chk("R10 last word", w, 16'h3CC3);
    rd_word(6'd0, w);
    chk("R10 first word", w, 16'h5AA5);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_idle_ignored();
    t_flag_sticky();
    t_overrun();
    t_bounds();
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule